// File: doc/BRIEF.md
# Buffered SPI Master

This block is an SPI master with one holding register for outgoing data and one for incoming data, each in front of a single shift engine. The host writes a control word, writes frames into the transmit holding register and reads received frames back. Status flags and three interrupt lines tell it when to do so. The serial clock is a power-of-two division of the system clock. Clock polarity and phase, 8- or 16-bit frames and bit order can each be chosen.

Because the next frame can be written while the current frame is still shifting, a stream of frames goes out with no idle clock between them. A single-wire half-duplex option uses the MOSI line for data in both directions. An active-low slave-select input reports a conflicting master: it disables the block and latches a fault.

Control word layout (bit positions): [2:0] rate n, [3] polarity, [4] phase, [5] 16-bit frame, [6] LSB first, [7] master, [8] enable, [9] single-wire mode, [10] single-wire drive, [11] transmit-empty interrupt enable, [12] receive-full interrupt enable, [13] error interrupt enable.

Top module: `spi_buffered_master`

## Requirements
- R1: With rate field n, each SCK half period lasts 2^n system clocks, so one frame of N bits keeps `busy` high for 2*N*2^n cycles.
- R2: Polarity bit 3 sets the idle SCK level. Phase bit 4 = 0 samples on the first (leading) edge of each bit, and phase = 1 samples on the second (trailing) edge. Transmitted data is stable at every sampling edge.
- R3: Bit 5 = 0 gives 8-bit frames, using data bits [7:0], with received data zero-extended. Bit 5 = 1 gives 16-bit frames.
- R4: Bit 6 = 0 sends and receives the most significant bit first. Bit 6 = 1 sends and receives the least significant bit first.
- R5: A write to the transmit register while `txe` = 1 clears `txe`. The frame is loaded into the shifter on the next cycle if the block is idle and enabled (bits 7 and 8 set). At that load `txe` returns to 1 and `busy` rises.
- R6: At the last sampling edge of a frame, the received word appears on `rd_data` and `rxne` is set. A `rd_en` pulse clears `rxne`.
- R7: A frame written while another is shifting starts right after it, with no idle SCK time, so two frames take exactly twice the time of one.
- R8: A transmit write while `txe` = 0 is ignored.
- R9: A frame completing while `rxne` = 1 sets `ovr` and replaces the buffered word. `ovr` clears only on a `rd_en` that follows a `stat_rd`.
- R10: `irq_tx` = `txe` with bit 11, `irq_rx` = `rxne` with bit 12, and `irq_err` = (`ovr` or `modf`) with bit 13.
- R11: `ss_n` low while master and enable are set clears both bits, aborts any transfer and sets `modf`. A `stat_rd` clears `modf`.
- R12: Single-wire mode (bit 9) takes received bits from `mosi_i`. `mosi_oe` is then equal to bit 10. Outside this mode `mosi_oe` is 1 and data is taken from `miso`.
- R13: A control write made while `busy` is 1 takes effect only once the block is idle. While idle, SCK sits at the polarity level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_data | input | 14 | Control word |
| wr_en | input | 1 | Transmit register write strobe |
| wr_data | input | 16 | Frame to transmit |
| rd_en | input | 1 | Receive register read strobe |
| rd_data | output | 16 | Buffered received frame |
| stat_rd | input | 1 | Status read strobe |
| txe | output | 1 | Transmit register empty |
| rxne | output | 1 | Receive register full |
| busy | output | 1 | Transfer in progress |
| ovr | output | 1 | Receive overrun |
| modf | output | 1 | Slave-select fault |
| irq_tx | output | 1 | Transmit-empty interrupt |
| irq_rx | output | 1 | Receive-full interrupt |
| irq_err | output | 1 | Error interrupt |
| sck | output | 1 | Serial clock |
| mosi_o | output | 1 | Data out on MOSI |
| mosi_oe | output | 1 | MOSI output enable |
| mosi_i | input | 1 | MOSI line readback for single-wire receive |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low slave-select fault input |

## Verification
The assertions assume the host keeps to the flag protocol. It writes the control word only between whole transactions and pulses each strobe for one cycle. It holds `ss_n` high except when it deliberately tests a fault. The stimulus waits for `txe` before every accepted write, so an ignored write happens only where it is deliberately issued. It reads each frame well before the next one lands, except in the overrun test. A bench slave model follows SCK in whatever mode is configured. It drives MISO and records MOSI, so expected words come from plain arithmetic on the values written.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int RATE_W = 3;

  typedef struct packed {
    logic              err_ie;
    logic              rx_ie;
    logic              tx_ie;
    logic              one_wire_drive;
    logic              one_wire;
    logic              enable;
    logic              master;
    logic              lsb_first;
    logic              wide;
    logic              cpha;
    logic              cpol;
    logic [RATE_W-1:0] rate;
  } spim_cfg_t;

  localparam int CFG_W = $bits(spim_cfg_t);
endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = CNT_W'((1 << rate) - 1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == lim) cnt <= '0;
    else cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic          wide,
  input  logic          lsb_first,
  input  logic          shift_en,
  input  logic          cap_en,
  input  logic          rx_bit,
  output logic          tx_bit,
  output logic [DW-1:0] rx_word
);
  logic [DW-1:0] tx_sh;
  logic [DW-1:0] rx_sh;
  logic [DW-1:0] rx_next;

  assign rx_next = lsb_first ? {rx_bit, rx_sh[DW-1:1]} : {rx_sh[DW-2:0], rx_bit};
  assign rx_word = wide      ? rx_next :
                   lsb_first ? DW'(rx_next[DW-1 -: SW]) : DW'(rx_next[SW-1:0]);
  assign tx_bit  = lsb_first ? tx_sh[0] : (wide ? tx_sh[DW-1] : tx_sh[SW-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (load) tx_sh <= load_word;
      else if (shift_en) tx_sh <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
      if (load) rx_sh <= '0;
      else if (cap_en) rx_sh <= rx_next;
    end
  end
endmodule

// File: rtl/spi_buffered_master.sv
module spi_buffered_master
  import spim_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  input  logic             stat_rd,
  output logic             txe,
  output logic             rxne,
  output logic             busy,
  output logic             ovr,
  output logic             modf,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_err,
  output logic             sck,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             mosi_i,
  input  logic             miso,
  input  logic             ss_n
);
  localparam int EW = $clog2(2 * DW);

  spim_cfg_t     cfg_q, cfg_act;
  logic [DW-1:0] tx_buf;
  logic [EW-1:0] edge_cnt, last_idx, samp_idx;
  logic          tick, fault, start, reload, load, ovr_armed;
  logic          samp_par, sample, shift_en, last_edge, rx_load, rx_src;
  logic [DW-1:0] rx_word;

  assign fault     = cfg_act.master && cfg_act.enable && !ss_n;
  assign start     = !busy && cfg_act.master && cfg_act.enable && !txe && !fault;
  assign last_idx  = cfg_act.wide ? EW'(2 * DW - 1) : EW'(2 * SW - 1);
  assign samp_idx  = cfg_act.cpha ? last_idx : last_idx - EW'(1);
  assign samp_par  = (edge_cnt[0] == cfg_act.cpha);
  assign sample    = tick && samp_par;
  assign shift_en  = tick && !samp_par && (edge_cnt != '0);
  assign last_edge = tick && (edge_cnt == last_idx);
  assign rx_load   = sample && (edge_cnt == samp_idx);
  assign reload    = last_edge && !txe;
  assign load      = start || reload;
  assign rx_src    = cfg_act.one_wire ? mosi_i : miso;

  assign irq_tx  = txe && cfg_act.tx_ie;
  assign irq_rx  = rxne && cfg_act.rx_ie;
  assign irq_err = (ovr || modf) && cfg_act.err_ie;
  assign mosi_oe = !cfg_act.one_wire || cfg_act.one_wire_drive;

  spim_clkgen #(.RATE_W(RATE_W)) clkgen_i (
    .clk (clk),
    .rst (rst),
    .run (busy),
    .rate(cfg_act.rate),
    .tick(tick)
  );

  spim_shifter #(.DW(DW), .SW(SW)) shifter_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_word(tx_buf),
    .wide     (cfg_act.wide),
    .lsb_first(cfg_act.lsb_first),
    .shift_en (shift_en),
    .cap_en   (sample),
    .rx_bit   (rx_src),
    .tx_bit   (mosi_o),
    .rx_word  (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      cfg_act   <= '0;
      tx_buf    <= '0;
      txe       <= 1'b1;
      rxne      <= 1'b0;
      busy      <= 1'b0;
      ovr       <= 1'b0;
      ovr_armed <= 1'b0;
      modf      <= 1'b0;
      edge_cnt  <= '0;
      sck       <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (cfg_wr) cfg_q <= spim_cfg_t'(cfg_data);
      // configuration reaches the engine only between transfers
      if (!busy && !start) begin
        cfg_act <= cfg_q;
        sck     <= cfg_q.cpol;
      end
      if (wr_en && txe) begin
        tx_buf <= wr_data;
        txe    <= 1'b0;
      end
      if (start) begin
        busy     <= 1'b1;
        txe      <= 1'b1;
        edge_cnt <= '0;
      end else if (tick) begin
        sck <= ~sck;
        if (edge_cnt == last_idx) begin
          edge_cnt <= '0;
          if (reload) txe <= 1'b1;
          else busy <= 1'b0;
        end else begin
          edge_cnt <= edge_cnt + EW'(1);
        end
      end
      // overrun clears on a data read that follows a status read
      if (stat_rd && ovr) ovr_armed <= 1'b1;
      if (rd_en && ovr_armed) begin
        ovr       <= 1'b0;
        ovr_armed <= 1'b0;
      end
      if (rx_load) begin
        rd_data <= rx_word;
        rxne    <= 1'b1;
        if (rxne && !rd_en) ovr <= 1'b1;
      end else if (rd_en) begin
        rxne <= 1'b0;
      end
      if (stat_rd && modf) modf <= 1'b0;
      if (fault) begin
        modf           <= 1'b1;
        cfg_q.master   <= 1'b0;
        cfg_q.enable   <= 1'b0;
        cfg_act.master <= 1'b0;
        cfg_act.enable <= 1'b0;
        busy           <= 1'b0;
        edge_cnt       <= '0;
        sck            <= cfg_act.cpol;
      end
    end
  end
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          sck,
  input logic          cpol,
  input logic          txe,
  input logic          wr_en,
  input logic          rd_en,
  input logic          rxne,
  input logic          ovr,
  input logic          modf,
  input logic          rx_load,
  input logic          fault,
  input logic [DW-1:0] tx_buf
);
  // R13 / R2: idle clock level follows polarity
  p_sck_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sck == cpol));

  // R5: transmit register reads empty once its frame is in the shifter
  p_txe_on_load_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> txe);

  // R8: writes into a full transmit register leave it untouched
  p_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !txe) |=> $stable(tx_buf));

  // R6: a read with no frame landing empties the receive register
  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rx_load) |=> !rxne);

  // R9: a frame landing on a full receive register flags overrun
  p_overrun_set_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_load && rxne && !rd_en) |=> ovr);

  // R9: overrun holds until a data read
  p_overrun_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ovr && !rd_en) |=> ovr);

  // R11: slave-select fault stops the engine and latches
  p_fault_r11: assert property (@(posedge clk) disable iff (rst)
    fault |=> (modf && !busy));
endmodule

bind spi_buffered_master spim_checker #(.DW(DW)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .sck    (sck),
  .cpol   (cfg_act.cpol),
  .txe    (txe),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .rxne   (rxne),
  .ovr    (ovr),
  .modf   (modf),
  .rx_load(rx_load),
  .fault  (fault),
  .tx_buf (tx_buf)
);

// File: tb/spi_buffered_master_tb.sv
module spi_buffered_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [13:0] cfg_data = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        stat_rd = 1'b0;
  logic        txe, rxne, busy, ovr, modf, irq_tx, irq_rx, irq_err;
  logic        sck, mosi_o, mosi_oe;
  logic        mosi_i = 1'b0;
  logic        miso = 1'b0;
  logic        ss_n = 1'b1;

  always #4 clk = ~clk;

  spi_buffered_master dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .stat_rd(stat_rd), .txe(txe), .rxne(rxne), .busy(busy), .ovr(ovr),
    .modf(modf), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
    .sck(sck), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso(miso), .ss_n(ss_n)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // bench slave model state
  bit          cur_cpol, cur_cpha, cur_wide, cur_lsb;
  logic [15:0] sv [0:3];
  logic [15:0] cap [0:15];
  int          ncap = 0;
  int          trk_gen = 0;
  int          seen_gen = 0;
  int          scnt = 0;
  int          fidx = 0;
  logic [15:0] wbuf = '0;
  logic        mosi_prev = 1'b0;
  logic        lead_e;
  logic        sbit;
  int          nb_t;
  int          busy_cnt = 0;

  always @(negedge clk) begin
    mosi_prev <= mosi_o;
    if (busy) busy_cnt <= busy_cnt + 1;
  end

  always @(sck or trk_gen) begin
    nb_t = cur_wide ? 16 : 8;
    if (trk_gen != seen_gen) begin
      seen_gen = trk_gen;
      scnt = 0;
      fidx = 0;
      wbuf = '0;
    end else begin
      lead_e = (sck != cur_cpol);
      if (lead_e ^ cur_cpha) begin
        if (cur_lsb) wbuf[scnt] = mosi_prev;
        else wbuf[nb_t-1-scnt] = mosi_prev;
        scnt = scnt + 1;
        if (scnt == nb_t) begin
          cap[ncap % 16] = wbuf;
          ncap = ncap + 1;
          scnt = 0;
          fidx = fidx + 1;
          wbuf = '0;
        end
      end
    end
    sbit = cur_lsb ? sv[fidx % 4][scnt] : sv[fidx % 4][nb_t-1-scnt];
    miso   = sbit;
    mosi_i = ~sbit;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(input int rate, input bit cpol, input bit cpha,
                                     input bit wide, input bit lsb, input bit ow,
                                     input bit owd, input bit ie);
    return {ie, ie, ie, owd, ow, 1'b1, 1'b1, lsb, wide, cpha, cpol, 3'(rate)};
  endfunction

  task automatic apply_cfg(input logic [13:0] c);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = c;
    @(negedge clk); cfg_wr = 1'b0;
    repeat (3) @(negedge clk);
    cur_rate_dummy(c);
    trk_gen = trk_gen + 1;
    @(negedge clk);
  endtask

  task automatic cur_rate_dummy(input logic [13:0] c);
    cur_cpol = c[3]; cur_cpha = c[4]; cur_wide = c[5]; cur_lsb = c[6];
  endtask

  task automatic write_tx(input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic run_pair(input logic [13:0] c, input logic [15:0] a, input logic [15:0] b,
                          input logic [15:0] sa, input logic [15:0] sb,
                          input bit inv, input bit extra_wr);
    int nb, half, base, n0;
    logic [15:0] m;
    sv[0] = sa; sv[1] = sb;
    apply_cfg(c);
    nb = c[5] ? 16 : 8;
    half = 1 << c[2:0];
    m = c[5] ? 16'hFFFF : 16'h00FF;
    base = busy_cnt;
    n0 = ncap;
    write_tx(a);
    chk("R5 txe cleared by write", {31'd0, txe}, 32'd0);
    @(negedge clk);
    chk("R5 txe set at load", {31'd0, txe}, 32'd1);
    chk("R5 busy at load", {31'd0, busy}, 32'd1);
    write_tx(b);
    if (extra_wr) write_tx(16'hDEAD);
    while (!rxne) @(negedge clk);
    chk("R6 first frame received", 32'(rd_data), 32'((inv ? ~sa : sa) & m));
    pulse_rd();
    chk("R6 rxne cleared by read", {31'd0, rxne}, 32'd0);
    while (!rxne) @(negedge clk);
    chk("R6 second frame received", 32'(rd_data), 32'((inv ? ~sb : sb) & m));
    pulse_rd();
    while (busy) @(negedge clk);
    chk("R1 R7 gap-free busy length", 32'(busy_cnt - base), 32'(4 * nb * half));
    chk("R2 R3 R4 first frame on wire", 32'(cap[n0 % 16]), 32'(a & m));
    chk("R2 R3 R4 second frame on wire", 32'(cap[(n0 + 1) % 16]), 32'(b & m));
    chk("R8 frame count on wire", 32'(ncap - n0), 32'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    sv[0] = 16'h0; sv[1] = 16'h0; sv[2] = 16'h0; sv[3] = 16'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R5 reset txe", {31'd0, txe}, 32'd1);
    chk("R6 reset rxne", {31'd0, rxne}, 32'd0);
    chk("R5 reset busy", {31'd0, busy}, 32'd0);
    chk("R13 reset sck", {31'd0, sck}, 32'd0);
    chk("R9 reset ovr", {31'd0, ovr}, 32'd0);
    chk("R11 reset modf", {31'd0, modf}, 32'd0);
    chk("R10 reset irq_tx", {31'd0, irq_tx}, 32'd0);
    chk("R12 reset mosi_oe", {31'd0, mosi_oe}, 32'd1);

    // sweep of modes, widths, orders and two rates
    for (int i = 0; i < 32; i++) begin
      logic [13:0] c;
      c = mk(i[4] ? 2 : 0, i[0], i[1], i[2], i[3], 1'b0, 1'b0, 1'b0);
      run_pair(c, 16'h1234 + 16'(i * 16'h0F1D), 16'hB00F ^ 16'(i * 16'h2461),
               16'h9C3A ^ 16'(i * 16'h0777), 16'h5A69 + 16'(i * 16'h1111), 1'b0, i == 5);
      chk("R13 idle sck at polarity", {31'd0, sck}, {31'd0, i[0]});
    end
    // slowest rate
    run_pair(mk(7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0), 16'h00A7, 16'h003C,
             16'h0081, 16'h00E2, 1'b0, 1'b0);

    // single-wire receive then drive
    run_pair(mk(1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0), 16'h4D2B, 16'hE1F0,
             16'h3C96, 16'h0F5A, 1'b1, 1'b0);
    chk("R12 single-wire receive oe", {31'd0, mosi_oe}, 32'd0);
    apply_cfg(mk(1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0));
    chk("R12 single-wire drive oe", {31'd0, mosi_oe}, 32'd1);

    // overrun and interrupts
    sv[0] = 16'h0011; sv[1] = 16'h0022;
    apply_cfg(mk(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    chk("R10 irq_tx when empty", {31'd0, irq_tx}, 32'd1);
    chk("R10 irq_rx when nothing received", {31'd0, irq_rx}, 32'd0);
    write_tx(16'h0071);
    while (!txe) @(negedge clk);
    write_tx(16'h0072);
    while (busy) @(negedge clk);
    chk("R9 overrun set", {31'd0, ovr}, 32'd1);
    chk("R9 newest frame kept", 32'(rd_data), 32'h22);
    chk("R10 irq_rx", {31'd0, irq_rx}, 32'd1);
    chk("R10 irq_err on overrun", {31'd0, irq_err}, 32'd1);
    pulse_rd();
    chk("R6 rxne cleared", {31'd0, rxne}, 32'd0);
    chk("R9 read alone keeps overrun", {31'd0, ovr}, 32'd1);
    pulse_stat();
    pulse_rd();
    chk("R9 status then read clears overrun", {31'd0, ovr}, 32'd0);

    // slave-select fault
    @(negedge clk); ss_n = 1'b0;
    @(negedge clk); ss_n = 1'b1;
    chk("R11 modf set", {31'd0, modf}, 32'd1);
    chk("R10 irq_err on fault", {31'd0, irq_err}, 32'd1);
    write_tx(16'h0055);
    repeat (20) @(negedge clk);
    chk("R11 disabled after fault", {31'd0, busy}, 32'd0);
    chk("R11 sck idle after fault", {31'd0, sck}, 32'd0);
    pulse_stat();
    chk("R11 modf cleared by status read", {31'd0, modf}, 32'd0);
    apply_cfg(mk(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    while (busy) @(negedge clk);
    if (rxne) pulse_rd();

    // configuration written mid-transfer is deferred
    sv[0] = 16'h1357;
    apply_cfg(mk(2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    begin
      int n0;
      n0 = ncap;
      write_tx(16'hC3A5);
      repeat (5) @(negedge clk);
      @(negedge clk); cfg_wr = 1'b1;
      cfg_data = mk(0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      @(negedge clk); cfg_wr = 1'b0;
      while (busy) @(negedge clk);
      chk("R13 frame kept old order", 32'(cap[n0 % 16]), 32'hC3A5);
      chk("R13 sck old level at end", {31'd0, sck}, 32'd0);
      @(negedge clk);
      chk("R13 new polarity once idle", {31'd0, sck}, 32'd1);
    end
    if (rxne) pulse_rd();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule